// File: doc/BRIEF.md
# Cumulative Monobit Bias Monitor

This block watches the decimated output of a hardware random bit source and keeps a running tally of its bias. Every accepted bit contributes +1 (for a one) or -1 (for a zero) to a signed walk, and a counter records how many bits have been accepted since the last clear. After each update the block tests whether the walk has strayed beyond three standard deviations of an ideal fair coin, that is whether |S| >= 3*sqrt(n). It compares squares, S*S against 9*n, so no square-root unit is needed. Any breach latches an alarm.

The monitor is meant to run over very long records. Both registers saturate instead of wrapping. When the counter reaches its ceiling the monitor freezes and raises a status flag. A start-up threshold holds off the test until enough bits have arrived for the bound to mean something. A single clear input restarts the record.

Top module: `bias_walk_monitor`

## Requirements
- R1: After reset, sum_o = 0, count_o = 0, alarm_o = 0 and sat_o = 0.
- R2: A clock edge with valid_i = 1 (and clr_i = 0, sat_o = 0) adds +1 to sum_o when bit_i = 1 and -1 when bit_i = 0, and increments count_o by one; the new values are visible after that edge.
- R3: An edge with valid_i = 0 and clr_i = 0 leaves sum_o, count_o, alarm_o and sat_o unchanged.
- R4: On the edge that accepts the bit making the count n >= MIN_COUNT, alarm_o becomes 1 if S_n*S_n >= 9*n, where S_n is the updated sum; this applies to positive and negative sums alike.
- R5: alarm_o stays 0 while count_o < MIN_COUNT, even if the squared bound is already exceeded.
- R6: Once set, alarm_o stays 1 until a clear or a reset.
- R7: clr_i = 1 at an edge zeroes sum_o, count_o, alarm_o and sat_o, and takes priority over a valid bit in the same cycle (that bit is dropped).
- R8: sum_o saturates at +(2^(SUM_W-1)-1) and -(2^(SUM_W-1)-1). The most negative two's complement value is never reached.
- R9: When count_o reaches 2^CNT_W-1, sat_o becomes 1 on the same edge. From then on, valid bits change neither sum_o nor count_o until a clear.
- R10: A strictly alternating bit stream never raises alarm_o, and its sum stays within {0, +1} when it starts with a one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous restart of the record |
| bit_i | input | 1 | Decimated random bit |
| valid_i | input | 1 | Strobe: bit_i is accepted on this edge |
| sum_o | output | SUM_W | Signed cumulative walk S_n |
| count_o | output | CNT_W | Number of bits accepted since clear |
| alarm_o | output | 1 | Sticky bias alarm |
| sat_o | output | 1 | Count ceiling reached, monitor frozen |

## Verification
An unbroken run of ones checks the exact alarm boundary. With the start-up threshold above the point where n*n >= 9n first holds, the test separates gating from the squared comparison, and the same run goes on into both saturations. A run of zeros checks the same behaviour for a negative walk. A mostly-ones pattern that sits one step below the bound at the threshold, then crosses it one bit later, catches an off-by-one in the >= comparison. An alternating stream checks that a balanced source never alarms. Short hand-written vectors cover bit mapping, idle cycles and clear taking priority over a valid bit.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // What the state registers do on the coming edge.
    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_CLEAR  = 2'd1,
        UPD_STEP   = 2'd2,
        UPD_FROZEN = 2'd3
    } upd_e;

endpackage

// File: rtl/bwm_step_sel.sv
module bwm_step_sel
    import bwm_pkg::*;
(
    input  logic clr_i,
    input  logic valid_i,
    input  logic sat_i,
    output upd_e upd_o
);
    // Clear wins over everything; a full counter freezes the record.
    always_comb begin
        if (clr_i)
            upd_o = UPD_CLEAR;
        else if (!valid_i)
            upd_o = UPD_HOLD;
        else if (sat_i)
            upd_o = UPD_FROZEN;
        else
            upd_o = UPD_STEP;
    end
endmodule

// File: rtl/bwm_sum_sat.sv
module bwm_sum_sat #(
    parameter int SUM_W = 24
) (
    input  logic signed [SUM_W-1:0] sum_i,
    input  logic                    bit_i,
    output logic signed [SUM_W-1:0] sum_o
);
    // Symmetric limits keep the magnitude representable in SUM_W-1 bits.
    localparam logic signed [SUM_W-1:0] SUM_MAX = {1'b0, {(SUM_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SUM_MIN = -SUM_MAX;
    localparam logic signed [SUM_W-1:0] ONE     = {{(SUM_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (bit_i)
            sum_o = (sum_i == SUM_MAX) ? sum_i : sum_i + ONE;
        else
            sum_o = (sum_i == SUM_MIN) ? sum_i : sum_i - ONE;
    end
endmodule

// File: rtl/bwm_cnt_sat.sv
module bwm_cnt_sat #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (cnt_i == CNT_MAX)
            cnt_o = cnt_i;
        else
            cnt_o = cnt_i + CNT_ONE;
        full_o = (cnt_o == CNT_MAX);
    end
endmodule

// File: rtl/bwm_bound.sv
module bwm_bound #(
    parameter int SUM_W     = 24,
    parameter int CNT_W     = 32,
    parameter int MIN_COUNT = 64
) (
    input  logic signed [SUM_W-1:0] sum_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic                    over_o
);
    localparam int SQ_W  = 2 * SUM_W;
    localparam int NIN_W = CNT_W + 4;
    localparam int CMP_W = (SQ_W > NIN_W) ? SQ_W : NIN_W;
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_COUNT);

    logic [SUM_W-1:0] mag;
    logic [CMP_W-1:0] mag_w;
    logic [CMP_W-1:0] cnt_w;
    logic [CMP_W-1:0] sq;
    logic [CMP_W-1:0] nine_n;

    always_comb begin
        // Saturation keeps sum_i away from the most negative code, so the
        // negated value always fits.
        mag    = sum_i[SUM_W-1] ? (~sum_i + 1'b1) : sum_i;
        mag_w  = CMP_W'(mag);
        cnt_w  = CMP_W'(cnt_i);
        sq     = mag_w * mag_w;
        nine_n = (cnt_w << 3) + cnt_w;
        over_o = (cnt_i >= MIN_CNT) && (sq >= nine_n);
    end
endmodule

// File: rtl/bias_walk_monitor.sv
module bias_walk_monitor
    import bwm_pkg::*;
#(
    parameter int SUM_W     = 24,
    parameter int CNT_W     = 32,
    parameter int MIN_COUNT = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    bit_i,
    input  logic                    valid_i,
    output logic signed [SUM_W-1:0] sum_o,
    output logic [CNT_W-1:0]        count_o,
    output logic                    alarm_o,
    output logic                    sat_o
);
    typedef struct packed {
        logic signed [SUM_W-1:0] sum;
        logic [CNT_W-1:0]        cnt;
        logic                    alarm;
        logic                    sat;
    } state_t;

    state_t st_d, st_q;

    upd_e                    upd;
    logic signed [SUM_W-1:0] sum_nx;
    logic [CNT_W-1:0]        cnt_nx;
    logic                    full_nx;
    logic                    over_nx;

    bwm_step_sel u_sel (
        .clr_i   (clr_i),
        .valid_i (valid_i),
        .sat_i   (st_q.sat),
        .upd_o   (upd)
    );

    bwm_sum_sat #(.SUM_W(SUM_W)) u_sum (
        .sum_i (st_q.sum),
        .bit_i (bit_i),
        .sum_o (sum_nx)
    );

    bwm_cnt_sat #(.CNT_W(CNT_W)) u_cnt (
        .cnt_i  (st_q.cnt),
        .cnt_o  (cnt_nx),
        .full_o (full_nx)
    );

    // The bound is judged on the updated pair, so the alarm lands on the
    // same edge as the bit that caused it.
    bwm_bound #(
        .SUM_W     (SUM_W),
        .CNT_W     (CNT_W),
        .MIN_COUNT (MIN_COUNT)
    ) u_bound (
        .sum_i  (sum_nx),
        .cnt_i  (cnt_nx),
        .over_o (over_nx)
    );

    always_comb begin
        st_d = st_q;
        case (upd)
            UPD_CLEAR: begin
                st_d.sum   = '0;
                st_d.cnt   = '0;
                st_d.alarm = 1'b0;
                st_d.sat   = 1'b0;
            end
            UPD_STEP: begin
                st_d.sum   = sum_nx;
                st_d.cnt   = cnt_nx;
                st_d.sat   = full_nx;
                st_d.alarm = st_q.alarm | over_nx;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign sum_o   = st_q.sum;
    assign count_o = st_q.cnt;
    assign alarm_o = st_q.alarm;
    assign sat_o   = st_q.sat;
endmodule

// File: rtl/bias_walk_monitor_chk.sv
module bias_walk_monitor_chk #(
    parameter int SUM_W     = 24,
    parameter int CNT_W     = 32,
    parameter int MIN_COUNT = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr_i,
    input logic                    valid_i,
    input logic signed [SUM_W-1:0] sum_o,
    input logic [CNT_W-1:0]        count_o,
    input logic                    alarm_o,
    input logic                    sat_o
);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_COUNT);
    localparam logic [SUM_W-1:0] SUM_NEG = {1'b1, {(SUM_W-1){1'b0}}};

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clr_i && !sat_o) |=> (count_o == $past(count_o) + 1'b1));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clr_i) |=> ($stable(sum_o) && $stable(count_o)
                                  && $stable(alarm_o) && $stable(sat_o)));

    a_r5_no_early_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o < MIN_CNT) |-> !alarm_o);

    a_r6_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && !clr_i) |=> alarm_o);

    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0 && sum_o == '0 && !alarm_o && !sat_o));

    a_r8_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o != SUM_NEG);

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_o && !clr_i) |=> ($stable(count_o) && $stable(sum_o) && sat_o));
endmodule

bind bias_walk_monitor bias_walk_monitor_chk #(
    .SUM_W     (SUM_W),
    .CNT_W     (CNT_W),
    .MIN_COUNT (MIN_COUNT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .valid_i (valid_i),
    .sum_o   (sum_o),
    .count_o (count_o),
    .alarm_o (alarm_o),
    .sat_o   (sat_o)
);

// File: tb/bias_walk_monitor_test.sv
module bias_walk_monitor_test;
    localparam int SW   = 5;   // sum limits +/-15
    localparam int CW   = 6;   // count ceiling 63
    localparam int MINC = 12;  // above 9, where n*n >= 9n first holds

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0;
    logic bit_i = 1'b0;
    logic valid_i = 1'b0;
    logic signed [SW-1:0] sum_o;
    logic [CW-1:0]        count_o;
    logic                 alarm_o;
    logic                 sat_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bias_walk_monitor #(.SUM_W(SW), .CNT_W(CW), .MIN_COUNT(MINC)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .bit_i   (bit_i),
        .valid_i (valid_i),
        .sum_o   (sum_o),
        .count_o (count_o),
        .alarm_o (alarm_o),
        .sat_o   (sat_o)
    );

    // Vector fields: {clr, valid, bit, exp_sum[4:0], exp_cnt[5:0], exp_alarm}
    localparam int NV = 12;
    localparam logic [14:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 5'h01, 6'd1, 1'b0},  // R2 +1
        {1'b0, 1'b1, 1'b1, 5'h02, 6'd2, 1'b0},  // R2 +1
        {1'b0, 1'b0, 1'b0, 5'h02, 6'd2, 1'b0},  // R3 idle
        {1'b0, 1'b1, 1'b0, 5'h01, 6'd3, 1'b0},  // R2 -1
        {1'b0, 1'b1, 1'b0, 5'h00, 6'd4, 1'b0},  // R2 -1
        {1'b0, 1'b1, 1'b0, 5'h1f, 6'd5, 1'b0},  // R2 to -1
        {1'b0, 1'b0, 1'b1, 5'h1f, 6'd5, 1'b0},  // R3 idle with bit high
        {1'b1, 1'b1, 1'b1, 5'h00, 6'd0, 1'b0},  // R7 clear beats valid
        {1'b0, 1'b1, 1'b0, 5'h1f, 6'd1, 1'b0},  // R2
        {1'b0, 1'b1, 1'b0, 5'h1e, 6'd2, 1'b0},  // R2
        {1'b1, 1'b0, 1'b0, 5'h00, 6'd0, 1'b0},  // R7 clear
        {1'b0, 1'b1, 1'b1, 5'h01, 6'd1, 1'b0}   // R2 after clear
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int s, input int n,
                           input int a, input int f);
        chk({tag, " sum"},   int'(sum_o), s);
        chk({tag, " count"}, int'(count_o), n);
        chk({tag, " alarm"}, int'(alarm_o), a);
        chk({tag, " sat"},   int'(sat_o), f);
    endtask

    // Called at a falling edge: drive, cross one rising edge, return at the
    // next falling edge with outputs settled.
    task automatic apply(input logic c, input logic v, input logic b);
        clr_i = c; valid_i = v; bit_i = b;
        @(negedge clk);
        clr_i = 1'b0; valid_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][14], VEC[i][13], VEC[i][12]);
            chk("R2/R3/R7 vector sum",   int'(sum_o), int'($signed(VEC[i][11:7])));
            chk("R2/R3/R7 vector count", int'(count_o), int'(VEC[i][6:1]));
            chk("R2/R3/R7 vector alarm", int'(alarm_o), int'(VEC[i][0]));
        end

        // All ones: gating, exact alarm point, sum and count saturation.
        apply(1'b1, 1'b0, 1'b0);
        for (int i = 1; i <= 63; i++) begin
            apply(1'b0, 1'b1, 1'b1);
            if (i == 11) chk("R5 gated at n=11", int'(alarm_o), 0);
            if (i == 12) chk("R4 alarm at n=12 ones", int'(alarm_o), 1);
            if (i == 15) chk("R8 sum reaches +15", int'(sum_o), 15);
            if (i == 16) chk("R8 sum held at +15", int'(sum_o), 15);
            if (i == 62) chk("R9 sat low at 62", int'(sat_o), 0);
            chk("R2 ones count", int'(count_o), i);
            chk("R4 R5 ones alarm", int'(alarm_o), (i >= MINC) ? 1 : 0);
        end
        chk_all("R9 ceiling reached", 15, 63, 1, 1);
        for (int i = 0; i < 3; i++) apply(1'b0, 1'b1, 1'b0);
        chk_all("R9 frozen after zeros", 15, 63, 1, 1);
        apply(1'b0, 1'b0, 1'b0);
        apply(1'b0, 1'b0, 1'b0);
        chk("R6 alarm sticky idle", int'(alarm_o), 1);
        apply(1'b1, 1'b0, 1'b0);
        chk_all("R7 clear after saturation", 0, 0, 0, 0);

        // All zeros: negative walk.
        for (int i = 1; i <= 20; i++) begin
            apply(1'b0, 1'b1, 1'b0);
            chk("R8 zeros sum", int'(sum_o), (i < 15) ? -i : -15);
            chk("R4 R5 zeros alarm", int'(alarm_o), (i >= MINC) ? 1 : 0);
        end

        // Boundary: one zero then ones; n=12 S=10 (100<108), n=13 S=11 (121>=117).
        apply(1'b1, 1'b0, 1'b0);
        apply(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 11; i++) apply(1'b0, 1'b1, 1'b1);
        chk_all("R4 below bound n=12", 10, 12, 0, 0);
        apply(1'b0, 1'b1, 1'b1);
        chk_all("R4 crosses bound n=13", 11, 13, 1, 0);

        // Reset mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1 reset mid-run", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Alternating stream.
        for (int i = 1; i <= 60; i++) begin
            apply(1'b0, 1'b1, (i % 2) == 1);
            chk("R10 alternating alarm", int'(alarm_o), 0);
            chk("R10 alternating sum", int'(sum_o), i % 2);
        end
        chk("R10 alternating count", int'(count_o), 60);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule